// File: doc/BRIEF.md
# Receive Frame Writer

This block sits between the receive MAC datapath and the packet buffer of a small Ethernet controller. When a frame is announced with its length, it checks that receive is enabled and that the formatted frame fits in one 2048-byte page. It then asks a page allocator for a page and writes the frame into that page in the controller's fixed layout. The layout is a 4-byte header, the frame data padded to the minimum size, an optional CRC-32 and a 2-byte trailer. When the last byte is written, it pushes the page number onto the receive queue and pulses the receive interrupt.

Frames are supplied one byte per cycle on a valid/ready stream once the page has been granted. A frame that is refused, whether by configuration, by size or for lack of a free page, is signalled with a one-cycle drop pulse. The source then discards it, and nothing is written to the buffer.

Top module: `rx_frame_writer`

## Requirements
- R1: A frame announced while receive is disabled (`rx_en` low) or while soft reset is held (`soft_rst` high) is dropped. One cycle after the announcement `drop` pulses, and no page is requested, no buffer byte is written and nothing is pushed.
- R2: The byte count is D + 6, plus 4 more when `strip_crc` is low. D is the frame length rounded down to even, or 64 when the length is below 64. A frame whose byte count would exceed 2048 is dropped with a `drop` pulse and no writes.
- R3: Page bytes 0 and 1 hold the 16-bit status word and bytes 2 and 3 hold the byte count, both least significant byte first.
- R4: Status bit 11 (0x0800) is set when the frame is longer than 1518 bytes. Bit 12 (0x1000) is set when the frame length is odd. All other status bits are zero.
- R5: Frame bytes are written in arrival order from page byte 4 on. A frame shorter than 64 bytes keeps all its bytes, including an odd last byte, followed by zero bytes up to 64 data bytes. A longer frame writes its even-length prefix there.
- R6: When `strip_crc` is low, the reflected Ethernet CRC-32 is written at byte 4 + D, least significant byte first. It uses polynomial 0x04C11DB7, initial value all ones and final inversion, and covers the padded frame including any odd last byte. When `strip_crc` is high, no CRC is written.
- R7: The last two page bytes are the trailer. A frame of 65 bytes or more with odd length gives its odd last byte followed by 0x60. Every other frame gives 0x00 followed by 0x40.
- R8: After the final trailer write, `rxq_push` and `rx_irq` are high together for exactly one cycle, with `rxq_page` equal to the granted page.
- R9: If the allocator refuses the request (`alloc_ok` low while `alloc_req` is high), `drop` pulses in the next cycle and no buffer byte is written for that frame.
- R10: An accepted frame writes every page byte from 0 to byte count − 1 exactly once, and never an address at or above the byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled at frame announcement |
| soft_rst | input | 1 | Soft reset held, frames refused |
| strip_crc | input | 1 | High: store no CRC |
| frm_start | input | 1 | Frame announcement strobe |
| frm_len | input | 12 | Frame length in bytes, valid with `frm_start` |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Frame byte accepted when high with `in_valid` |
| alloc_req | output | 1 | Page request, answered in the same cycle |
| alloc_ok | input | 1 | Allocator granted a page |
| alloc_page | input | 2 | Granted page number |
| wr_en | output | 1 | Buffer byte write strobe |
| wr_page | output | 2 | Page being written |
| wr_addr | output | 11 | Byte offset within the page |
| wr_data | output | 8 | Byte to write |
| rxq_push | output | 1 | Push page number onto receive queue |
| rxq_page | output | 2 | Page number pushed |
| rx_irq | output | 1 | Receive interrupt pulse |
| drop | output | 1 | Frame refused pulse |

## Verification
A refused announcement shows `drop` in the cycle after the announcement is sampled. `alloc_req` is high in that same cycle, and an allocator refusal raises `drop` one cycle later. Header writes occupy the four cycles after the grant, each data byte is written in the cycle it is accepted, and padding, CRC and trailer follow back to back. `rxq_push` and `rx_irq` come one cycle after the last trailer write. The bench drives inputs just after the rising edge and samples every output at the falling edge, recording each write and pulse in the cycle it occurs. It compares the whole page image and the pulse counts only after completion or drop has been seen.

// File: rtl/rfw_pkg.sv
// Shared types and the CRC step function for the receive frame writer.
// Assumes byte-serial operation: one CRC update per cycle.
package rfw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ALLOC,
        S_HDR,
        S_DATA,
        S_PAD,
        S_CRC,
        S_TRL,
        S_DONE
    } rfw_state_e;

    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // Advance a reflected CRC-32 by one byte, least significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rfw_layout.sv
// Frame layout calculator. From a frame length and the CRC-strip option it
// derives the stored data length, the total byte count, the status word and
// whether the frame fits one page. Purely combinational; assumes LEN_W < 16.
module rfw_layout #(
    parameter int LEN_W      = 12,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_STD    = 1518,
    parameter int PAGE_BYTES = 2048
) (
    input  logic [LEN_W-1:0] len,
    input  logic             strip,
    output logic [LEN_W-1:0] dlen,
    output logic [LEN_W:0]   total,
    output logic [15:0]      status,
    output logic             is_short,
    output logic             is_odd,
    output logic             fits
);
    localparam logic [LEN_W:0] EXTRA_NOCRC = (LEN_W+1)'(6);
    localparam logic [LEN_W:0] EXTRA_CRC   = (LEN_W+1)'(10);

    // Derive sizes and status bits from the announced length.
    always_comb begin
        is_short = len < LEN_W'(MIN_FRAME);
        is_odd   = len[0];
        dlen     = is_short ? LEN_W'(MIN_FRAME) : {len[LEN_W-1:1], 1'b0};
        total    = {1'b0, dlen} + (strip ? EXTRA_NOCRC : EXTRA_CRC);
        status   = 16'd0;
        status[11] = len > LEN_W'(MAX_STD);
        status[12] = is_odd;
        fits     = total <= (LEN_W+1)'(PAGE_BYTES);
    end

endmodule

// File: rtl/rfw_crc.sv
// Byte-serial CRC-32 accumulator. Cleared at the start of each frame, updated
// once per enabled cycle, and presents the inverted (final) value.
module rfw_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);
    import rfw_pkg::*;

    logic [31:0] crc_q;

    // Hold the running CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc_step(crc_q, data);
        end
    end

    assign crc_out = ~crc_q;

endmodule

// File: rtl/rx_frame_writer.sv
// Receive frame writer. Checks an announced frame, requests a page, writes
// header, data, padding, CRC and trailer into it one byte per cycle, then
// pushes the page onto the receive queue and pulses the interrupt.
// Assumes the allocator answers alloc_req in the same cycle and that the
// source discards a frame when drop pulses.
module rx_frame_writer #(
    parameter int LEN_W      = 12,
    parameter int PAGE_W     = 2,
    parameter int ADDR_W     = 11,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_STD    = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              soft_rst,
    input  logic              strip_crc,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              alloc_req,
    input  logic              alloc_ok,
    input  logic [PAGE_W-1:0] alloc_page,
    output logic              wr_en,
    output logic [PAGE_W-1:0] wr_page,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rxq_push,
    output logic [PAGE_W-1:0] rxq_page,
    output logic              rx_irq,
    output logic              drop
);
    import rfw_pkg::*;

    localparam int PAGE_BYTES = 1 << ADDR_W;
    localparam logic [LEN_W:0] HDR_BYTES = (LEN_W+1)'(4);
    localparam logic [LEN_W:0] CRC_BYTES = (LEN_W+1)'(4);

    rfw_state_e        state;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  dlen_q;
    logic [LEN_W:0]    total_q;
    logic [15:0]       status_q;
    logic              short_q;
    logic              odd_q;
    logic              strip_q;
    logic [7:0]        odd_byte_q;
    logic [PAGE_W-1:0] page_q;
    logic              drop_q;

    logic [LEN_W-1:0]  l_dlen;
    logic [LEN_W:0]    l_total;
    logic [15:0]       l_status;
    logic              l_short;
    logic              l_odd;
    logic              l_fits;

    logic              take;
    logic              last_in;
    logic              long_odd;
    logic              crc_en;
    logic [31:0]       crc_val;
    logic [15:0]       tot16;
    logic [LEN_W:0]    addr_full;
    logic [LEN_W:0]    tail_base;

    rfw_layout #(
        .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .MAX_STD(MAX_STD), .PAGE_BYTES(PAGE_BYTES)
    ) u_layout (
        .len(frm_len), .strip(strip_crc), .dlen(l_dlen), .total(l_total),
        .status(l_status), .is_short(l_short), .is_odd(l_odd), .fits(l_fits)
    );

    rfw_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(state == S_HDR), .en(crc_en),
        .data(in_data & {8{state == S_DATA}}), .crc_out(crc_val)
    );

    assign take     = (state == S_DATA) && in_valid;
    assign last_in  = cnt == len_q - LEN_W'(1);
    assign long_odd = odd_q && !short_q;
    assign crc_en   = take || (state == S_PAD);
    assign tot16    = 16'(total_q);
    assign tail_base = HDR_BYTES + {1'b0, dlen_q};

    // Sequence a frame through announcement, allocation and byte writing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cnt        <= '0;
            len_q      <= '0;
            dlen_q     <= '0;
            total_q    <= '0;
            status_q   <= '0;
            short_q    <= 1'b0;
            odd_q      <= 1'b0;
            strip_q    <= 1'b0;
            odd_byte_q <= '0;
            page_q     <= '0;
            drop_q     <= 1'b0;
        end else begin
            drop_q <= 1'b0;
            unique case (state)
                S_IDLE: if (frm_start) begin
                    len_q    <= frm_len;
                    dlen_q   <= l_dlen;
                    total_q  <= l_total;
                    status_q <= l_status;
                    short_q  <= l_short;
                    odd_q    <= l_odd;
                    strip_q  <= strip_crc;
                    cnt      <= '0;
                    if (!rx_en || soft_rst || !l_fits) drop_q <= 1'b1;
                    else state <= S_ALLOC;
                end
                S_ALLOC: begin
                    if (alloc_ok) begin
                        page_q <= alloc_page;
                        state  <= S_HDR;
                    end else begin
                        drop_q <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                S_HDR: begin
                    if (cnt == LEN_W'(3)) begin
                        cnt   <= '0;
                        state <= (len_q == '0) ? S_PAD : S_DATA;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                S_DATA: if (in_valid) begin
                    if (last_in) begin
                        odd_byte_q <= in_data;
                        if (short_q) begin
                            cnt   <= cnt + LEN_W'(1);
                            state <= S_PAD;
                        end else begin
                            cnt   <= '0;
                            state <= strip_q ? S_TRL : S_CRC;
                        end
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                S_PAD: begin
                    if (cnt == LEN_W'(MIN_FRAME - 1)) begin
                        cnt   <= '0;
                        state <= strip_q ? S_TRL : S_CRC;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                S_CRC: begin
                    if (cnt == LEN_W'(3)) begin
                        cnt   <= '0;
                        state <= S_TRL;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                S_TRL: begin
                    if (cnt == LEN_W'(1)) begin
                        cnt   <= '0;
                        state <= S_DONE;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Select the page offset of the byte written in this cycle.
    always_comb begin
        unique case (state)
            S_HDR:          addr_full = {1'b0, cnt};
            S_DATA, S_PAD:  addr_full = HDR_BYTES + {1'b0, cnt};
            S_CRC:          addr_full = tail_base + {1'b0, cnt};
            S_TRL:          addr_full = tail_base + (strip_q ? '0 : CRC_BYTES) + {1'b0, cnt};
            default:        addr_full = '0;
        endcase
    end

    // Select the byte value and write strobe for this cycle.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = 8'h00;
        unique case (state)
            S_HDR: begin
                wr_en = 1'b1;
                unique case (cnt[1:0])
                    2'd0: wr_data = status_q[7:0];
                    2'd1: wr_data = status_q[15:8];
                    2'd2: wr_data = tot16[7:0];
                    default: wr_data = tot16[15:8];
                endcase
            end
            S_DATA: begin
                wr_en   = in_valid && !(long_odd && last_in);
                wr_data = in_data;
            end
            S_PAD: wr_en = 1'b1;
            S_CRC: begin
                wr_en = 1'b1;
                unique case (cnt[1:0])
                    2'd0: wr_data = crc_val[7:0];
                    2'd1: wr_data = crc_val[15:8];
                    2'd2: wr_data = crc_val[23:16];
                    default: wr_data = crc_val[31:24];
                endcase
            end
            S_TRL: begin
                wr_en = 1'b1;
                if (cnt == '0) wr_data = long_odd ? odd_byte_q : 8'h00;
                else           wr_data = long_odd ? 8'h60 : 8'h40;
            end
            default: ;
        endcase
    end

    assign wr_addr   = addr_full[ADDR_W-1:0];
    assign wr_page   = page_q;
    assign in_ready  = state == S_DATA;
    assign alloc_req = state == S_ALLOC;
    assign rxq_push  = state == S_DONE;
    assign rxq_page  = page_q;
    assign rx_irq    = state == S_DONE;
    assign drop      = drop_q;

    // R1: a refused announcement drops without requesting a page
    a_r1_refused_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && frm_start && (!rx_en || soft_rst)) |=> (drop && !alloc_req && !wr_en));

    // R2: a frame being written always fits one page
    a_r2_fits_page: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR) |-> (total_q <= (LEN_W+1)'(PAGE_BYTES)));

    // R6: nothing is written in the CRC phase when stripping is on
    a_r6_no_crc_when_strip: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && strip_q) |-> (state != S_CRC));

    // R8: completion is a single-cycle pulse with no write beside it
    a_r8_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |=> (!rxq_push && !wr_en));

    // R9: a refused allocation drops and writes nothing
    a_r9_alloc_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_ok) |=> (drop && !wr_en && !in_ready));

    // R10: every write stays below the byte count
    a_r10_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((LEN_W+1)'(wr_addr) < total_q));

endmodule

// File: tb/sim_rx_frame_writer.sv
module sim_rx_frame_writer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;
    localparam int VLEN  [NV] = '{60, 61, 1, 64, 65, 100, 1519, 2043, 2043, 2044, 1518};
    localparam int VSTRIP[NV] = '{0,  0,  1, 0,  0,  1,   0,    1,    0,    1,    0};
    localparam int VOK   [NV] = '{1,  1,  1, 1,  1,  1,   1,    1,    0,    0,    1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, soft_rst = 1'b0, strip_crc = 1'b0;
    logic        frm_start = 1'b0;
    logic [11:0] frm_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, alloc_req, wr_en, rxq_push, rx_irq, drop;
    logic        alloc_ok = 1'b1;
    logic [1:0]  alloc_page = '0;
    logic [1:0]  wr_page, rxq_page;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0, errors = 0, cyc = 0;
    int wcount, push_cnt, irq_cnt, irq_with_push, drop_cnt, req_cnt, oor_cnt, push_pg, cur_total;
    logic [7:0] mem [0:2047];
    logic [7:0] expb[0:2047];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_writer u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst), .strip_crc(strip_crc),
        .frm_start(frm_start), .frm_len(frm_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_page(alloc_page),
        .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
        .rxq_push(rxq_push), .rxq_page(rxq_page), .rx_irq(rx_irq), .drop(drop)
    );

    // Record writes and pulses at the falling edge.
    always @(negedge clk) begin
        if (wr_en) begin
            mem[wr_addr] = wr_data;
            wcount++;
            if (int'(wr_addr) >= cur_total) oor_cnt++;
        end
        if (rxq_push) begin push_cnt++; push_pg = int'(rxq_page); end
        if (rx_irq) irq_cnt++;
        if (rx_irq && rxq_push) irq_with_push++;
        if (drop) drop_cnt++;
        if (alloc_req) req_cnt++;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * seed + seed * 3 + 1) & 255);
    endfunction

    // Bit-at-a-time reflected CRC-32, independent model.
    function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = r[0] ^ d[k];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic int dlen_of(input int len);
        return (len < 64) ? 64 : (len & ~1);
    endfunction

    function automatic int total_of(input int len, input int strip);
        return dlen_of(len) + 6 + (strip ? 0 : 4);
    endfunction

    // Build the expected page image for a frame.
    task automatic build_exp(input int len, input int strip, input int seed);
        int d, t, st, p;
        logic [31:0] c;
        d = dlen_of(len);
        t = total_of(len, strip);
        st = ((len > 1518) ? 'h0800 : 0) | ((len % 2) ? 'h1000 : 0);
        expb[0] = 8'(st); expb[1] = 8'(st >> 8);
        expb[2] = 8'(t);  expb[3] = 8'(t >> 8);
        c = 32'hFFFFFFFF;
        for (int j = 0; j < d; j++) begin
            expb[4 + j] = (j < len) ? pat(j, seed) : 8'h00;
            c = crc_bits(c, expb[4 + j]);
        end
        if (len >= 64 && (len % 2)) c = crc_bits(c, pat(len - 1, seed));
        c = ~c;
        p = 4 + d;
        if (!strip) begin
            for (int k = 0; k < 4; k++) expb[p + k] = 8'(c >> (8 * k));
            p += 4;
        end
        if (len >= 64 && (len % 2)) begin expb[p] = pat(len - 1, seed); expb[p + 1] = 8'h60; end
        else begin expb[p] = 8'h00; expb[p + 1] = 8'h40; end
    endtask

    task automatic run_frame(input int len, input int strip, input int page, input bit aok,
                             input bit en, input bit srst, input int seed);
        int i, guard;
        wcount = 0; push_cnt = 0; irq_cnt = 0; irq_with_push = 0; drop_cnt = 0;
        req_cnt = 0; oor_cnt = 0; push_pg = -1; cur_total = total_of(len, strip);
        for (int a = 0; a < 2048; a++) mem[a] = 8'hEE;
        @(posedge clk); #1;
        rx_en = en; soft_rst = srst; strip_crc = strip[0]; alloc_ok = aok;
        alloc_page = 2'(page); frm_len = 12'(len); frm_start = 1'b1;
        @(posedge clk); #1;
        frm_start = 1'b0;
        i = 0; guard = 0;
        while (i < len && drop_cnt == 0 && guard < 6000) begin
            in_valid = 1'b1; in_data = pat(i, seed);
            @(negedge clk);
            if (in_ready) i++;
            guard++;
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        guard = 0;
        while (push_cnt == 0 && drop_cnt == 0 && guard < 200) begin
            @(negedge clk); guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Compare a region of the captured page against the expected image.
    task automatic cmp_region(input int lo, input int hi, input string tag);
        int bad = -1;
        for (int a = lo; a < hi; a++) if (bad < 0 && mem[a] !== expb[a]) bad = a;
        if (bad < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, tag, int'(mem[bad]), int'(expb[bad]));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready && !wr_en && !alloc_req && !rxq_push && !rx_irq && !drop,
              "R8 reset idle outputs", {in_ready, wr_en, alloc_req, rxq_push, rx_irq, drop}, 0);

        // Table-driven frames
        for (int v = 0; v < NV; v++) begin
            int t, d;
            t = total_of(VLEN[v], VSTRIP[v]);
            d = dlen_of(VLEN[v]);
            run_frame(VLEN[v], VSTRIP[v], v % 4, 1'b1, 1'b1, 1'b0, v + 3);
            if (VOK[v]) begin
                build_exp(VLEN[v], VSTRIP[v], v + 3);
                cmp_region(0, 2, "R4 status word");
                cmp_region(2, 4, "R2 R3 byte count");
                cmp_region(4, 4 + d, "R5 data and padding");
                if (!VSTRIP[v]) cmp_region(4 + d, 8 + d, "R6 crc");
                cmp_region(t - 2, t, "R7 trailer");
                check(wcount == t && oor_cnt == 0, "R10 write count", wcount, t);
                check(push_cnt == 1 && irq_cnt == 1 && irq_with_push == 1,
                      "R8 push and irq single pulse", push_cnt * 16 + irq_cnt, 17);
                check(push_pg == v % 4, "R8 pushed page", push_pg, v % 4);
            end else begin
                check(drop_cnt == 1 && wcount == 0 && push_cnt == 0 && req_cnt == 0,
                      "R2 oversize drop", drop_cnt * 256 + wcount, 256);
            end
        end

        // Directed: receive disabled
        run_frame(80, 0, 1, 1'b1, 1'b0, 1'b0, 9);
        check(drop_cnt == 1 && req_cnt == 0 && wcount == 0 && push_cnt == 0,
              "R1 disabled drop", drop_cnt * 256 + req_cnt * 16 + wcount, 256);
        // Directed: soft reset held
        run_frame(80, 0, 1, 1'b1, 1'b1, 1'b1, 9);
        check(drop_cnt == 1 && req_cnt == 0 && wcount == 0 && push_cnt == 0,
              "R1 soft reset drop", drop_cnt * 256 + req_cnt * 16 + wcount, 256);
        // Directed: allocation refused
        run_frame(70, 0, 2, 1'b0, 1'b1, 1'b0, 5);
        check(drop_cnt == 1 && req_cnt == 1 && wcount == 0 && push_cnt == 0 && irq_cnt == 0,
              "R9 allocation refused", drop_cnt * 256 + req_cnt * 16 + wcount, 272);
        // Directed: recovery after refusal, odd long frame with CRC
        run_frame(127, 0, 3, 1'b1, 1'b1, 1'b0, 11);
        build_exp(127, 0, 11);
        cmp_region(0, total_of(127, 0), "R6 R7 frame after refusal");
        check(push_cnt == 1 && push_pg == 3, "R8 push after refusal", push_pg, 3);

        summary();
        $finish;
    end
endmodule